// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Controller

This block gathers a build-time number of level-sensitive request lines, either 32 or 64, into a status register. It qualifies them with an enable mask that software can write. The OR of all enabled requests drives one registered interrupt line toward the processor. A simple register port reads the status and reads or writes the whole mask. Two single-bit strobes enable or disable one source without disturbing the others.

When the interrupt handler wants to know which source to serve, it raises a service request for one cycle. On that clock edge a round-robin selector scans the enabled requests. The scan starts at a stored pointer and takes the first enabled one it meets. The result is reported as a one-cycle pulse, and the pointer moves to the index just after the source that was served. This way no source holds a fixed priority over the others.

A contiguous window of indices can be declared as cascaded external lines. A selection that falls inside the window is reported with an external flag and a number rebased to the start of the window.

Top module: `irq_rr_ctrl`

## Requirements
- R1: The status register captures `irqRaw` on every clock edge. A source is pending when its status bit and its mask bit are both 1; a mask bit of 1 enables the source.
- R2: `cpuIrq` is the OR of all pending bits, registered once, so it follows a change of status or mask by one clock.
- R3: A service request made while nothing is pending gives `selValid` = 0 and leaves the pointer unchanged, so a later selection resumes at the same index.
- R4: On a service request the scan checks the indices ptr, ptr+1, … in order, wrapping modulo WIDTH. The first pending index found is selected.
- R5: After a selection the pointer holds the selected index plus one, modulo WIDTH (WIDTH-1 wraps to 0).
- R6: `regAddr` = 1 selects the mask and `regAddr` = 0 selects the status. `regRdData` returns the selected register at full width. A write to address 1 loads the whole mask. A write to address 0 has no effect on the status.
- R7: `maskClrEn` clears only bit `maskIdx` of the mask and `maskSetEn` sets only that bit. All other bits keep their value. If both strobes are raised in the same cycle, the clear wins. A full-width mask write in the same cycle overrides both strobes.
- R8: With CASCADE_EN = 1 and the selected index i in [EXT_LO, EXT_HI] inclusive, `selNum` = i − EXT_LO and `selExt` = 1. Otherwise `selNum` = i and `selExt` = 0.
- R9: `selValid`, `selNum` and `selExt` are registered on the edge that samples `serviceReq`. The pointer updates on that same edge. `selValid` is high for exactly the one cycle after each sampled request.
- R10: Reset clears the mask, the status and the pointer to zero, and drives `cpuIrq` and `selValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqRaw | input | WIDTH | Level request lines |
| regAddr | input | 1 | Register select: 0 status, 1 mask |
| regWrEn | input | 1 | Full-width write strobe |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Read data of the selected register |
| maskSetEn | input | 1 | Enable the single source maskIdx |
| maskClrEn | input | 1 | Disable the single source maskIdx |
| maskIdx | input | IDXW | Source index for the single-bit strobes |
| serviceReq | input | 1 | Request a round-robin selection |
| cpuIrq | output | 1 | Combined registered interrupt |
| selValid | output | 1 | Selection pulse |
| selNum | output | IDXW | Selected number (rebased when external) |
| selExt | output | 1 | Selected source lies in the cascaded window |

## Verification
On every cycle the assertions check several relations. `cpuIrq` must follow the previous pending state. An idle service request must leave the pointer in place. After each pulse the pointer must sit just past the selected index. A pulse may come only from a sampled request. Single-bit mask strobes must land on the named bit, and any reported external number must fall inside the window. Only the bench scenarios can show fairness over long runs, which needs an independent model of the pointer: the full rotation with wrap, resumption after an idle request, and selection from sparse patterns. The same holds for the cascade numbering across the whole index space and for preserving the other mask bits during single-bit updates.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;
  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrMask;
    logic setBit;
    logic clrBit;
    logic serve;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_rr_ctl.sv
module irq_rr_ctl
  import irq_rr_pkg::*;
(
  input  logic         regAddr,
  input  logic         regWrEn,
  input  logic         maskSetEn,
  input  logic         maskClrEn,
  input  logic         serviceReq,
  output ctrl_strobe_t strobes
);
  always_comb begin
    strobes.wrMask = regWrEn & regAddr;
    // a whole-mask write overrides single-bit updates; clear beats set
    strobes.clrBit = maskClrEn & ~strobes.wrMask;
    strobes.setBit = maskSetEn & ~maskClrEn & ~strobes.wrMask;
    strobes.serve  = serviceReq;
  end
endmodule

// File: rtl/irq_rr_dp.sv
module irq_rr_dp
  import irq_rr_pkg::*;
#(
  parameter int WIDTH      = 64,
  parameter bit CASCADE_EN = 1'b1,
  parameter int EXT_LO     = 8,
  parameter int EXT_HI     = 11,
  localparam int IDXW      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] irqRaw,
  input  ctrl_strobe_t     strobes,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             rdSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             cpuIrq,
  output logic             selValid,
  output logic [IDXW-1:0]  selNum,
  output logic             selExt
);
  logic [WIDTH-1:0] statusReg;
  logic [WIDTH-1:0] maskReg;
  logic [WIDTH-1:0] pendingVec;
  logic [IDXW-1:0]  ptr;
  logic [IDXW-1:0]  hitIdx;
  logic [IDXW-1:0]  selRaw;
  logic             anyPending;
  logic             inWindow;
  logic [IDXW-1:0]  mappedNum;

  function automatic logic [IDXW-1:0] nextIdx(input logic [IDXW-1:0] i);
    return (int'(i) == WIDTH-1) ? '0 : i + 1'b1;
  endfunction

  assign pendingVec = statusReg & maskReg;
  assign anyPending = |pendingVec;
  assign rdData     = rdSel ? maskReg : statusReg;

  // status capture and mask register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusReg <= '0;
      maskReg   <= '0;
    end else begin
      statusReg <= irqRaw;
      if (strobes.wrMask)      maskReg         <= wrData;
      else if (strobes.clrBit) maskReg[bitIdx] <= 1'b0;
      else if (strobes.setBit) maskReg[bitIdx] <= 1'b1;
    end
  end

  // rotating first-one search starting at ptr
  always_comb begin
    logic found;
    found  = 1'b0;
    hitIdx = '0;
    for (int k = 0; k < WIDTH; k++) begin
      logic [IDXW-1:0] j;
      j = IDXW'((int'(ptr) + k) % WIDTH);
      if (!found && pendingVec[j]) begin
        found  = 1'b1;
        hitIdx = j;
      end
    end
  end

  // cascade window remap
  generate
    if (CASCADE_EN) begin : g_casc
      assign inWindow  = (int'(hitIdx) >= EXT_LO) && (int'(hitIdx) <= EXT_HI);
      assign mappedNum = inWindow ? hitIdx - IDXW'(EXT_LO) : hitIdx;
    end else begin : g_flat
      assign inWindow  = 1'b0;
      assign mappedNum = hitIdx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      selValid <= 1'b0;
      selNum   <= '0;
      selExt   <= 1'b0;
      selRaw   <= '0;
      cpuIrq   <= 1'b0;
    end else begin
      cpuIrq   <= anyPending;
      selValid <= strobes.serve & anyPending;
      if (strobes.serve && anyPending) begin
        ptr    <= nextIdx(hitIdx);
        selRaw <= hitIdx;
        selNum <= mappedNum;
        selExt <= inWindow;
      end
    end
  end

  // R2: combined line follows pending state of previous cycle
  a_r2_cpu_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cpuIrq == $past(|(statusReg & maskReg)));
  // R3: idle service request keeps pointer
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.serve && !anyPending) |=> $stable(ptr));
  // R5: pointer sits just past the served source
  a_r5_ptr_next: assert property (@(posedge clk) disable iff (!rst_n)
    selValid |-> (ptr == nextIdx(selRaw)));
  // R9: a pulse only follows a sampled request
  a_r9_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    selValid |-> $past(strobes.serve));
  // R7: single-bit strobes land on the named bit
  a_r7_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrBit |=> !maskReg[$past(bitIdx)]);
  a_r7_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setBit |=> maskReg[$past(bitIdx)]);
  // R8: external numbers stay inside the window
  a_r8_ext_range: assert property (@(posedge clk) disable iff (!rst_n)
    (selValid && selExt) |-> (int'(selNum) <= EXT_HI - EXT_LO));
endmodule

// File: rtl/irq_rr_ctrl.sv
module irq_rr_ctrl
  import irq_rr_pkg::*;
#(
  parameter int WIDTH      = 64,
  parameter bit CASCADE_EN = 1'b1,
  parameter int EXT_LO     = 8,
  parameter int EXT_HI     = 11,
  localparam int IDXW      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] irqRaw,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             maskSetEn,
  input  logic             maskClrEn,
  input  logic [IDXW-1:0]  maskIdx,
  input  logic             serviceReq,
  output logic             cpuIrq,
  output logic             selValid,
  output logic [IDXW-1:0]  selNum,
  output logic             selExt
);
  ctrl_strobe_t strobes;

  irq_rr_ctl u_ctl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .maskSetEn (maskSetEn),
    .maskClrEn (maskClrEn),
    .serviceReq(serviceReq),
    .strobes   (strobes)
  );

  irq_rr_dp #(
    .WIDTH(WIDTH), .CASCADE_EN(CASCADE_EN), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .irqRaw  (irqRaw),
    .strobes (strobes),
    .bitIdx  (maskIdx),
    .rdSel   (regAddr),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .cpuIrq  (cpuIrq),
    .selValid(selValid),
    .selNum  (selNum),
    .selExt  (selExt)
  );
endmodule

// File: tb/sim_irq_rr_ctrl.sv
`timescale 1ns/1ps
module sim_irq_rr_ctrl;
  localparam int W = 32;
  localparam int IW = 5;
  localparam int LO = 8;
  localparam int HI = 11;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] irqRaw = '0;
  logic regAddr = 0, regWrEn = 0, maskSetEn = 0, maskClrEn = 0, serviceReq = 0;
  logic [W-1:0] regWrData = '0;
  logic [IW-1:0] maskIdx = '0;
  logic [W-1:0] regRdData;
  logic cpuIrq, selValid, selExt;
  logic [IW-1:0] selNum;

  int checks = 0, errors = 0;
  logic [W-1:0] maskM = '0;
  int ptrM = 0;

  always #4 clk = ~clk;

  irq_rr_ctrl #(.WIDTH(W), .CASCADE_EN(1'b1), .EXT_LO(LO), .EXT_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .irqRaw(irqRaw), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .maskSetEn(maskSetEn), .maskClrEn(maskClrEn), .maskIdx(maskIdx),
    .serviceReq(serviceReq), .cpuIrq(cpuIrq), .selValid(selValid),
    .selNum(selNum), .selExt(selExt));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrMask(input logic [W-1:0] v);
    regAddr = 1; regWrEn = 1; regWrData = v; tick; regWrEn = 0;
    maskM = v;
  endtask

  task automatic serveOnce(input string req);
    logic [W-1:0] pend;
    bit v; int hit;
    pend = irqRaw & maskM;
    v = 0; hit = 0;
    for (int k = 0; k < W; k++) begin
      if (!v && pend[(ptrM + k) % W]) begin v = 1; hit = (ptrM + k) % W; end
    end
    serviceReq = 1; tick; serviceReq = 0;
    chk(selValid == v, req, selValid, v);
    if (v) begin
      bit e; int n;
      e = (hit >= LO && hit <= HI);
      n = e ? hit - LO : hit;
      chk(selExt == e, "R8", selExt, e);
      chk(int'(selNum) == n, req, selNum, n);
      ptrM = (hit + 1) % W;
    end
    tick;
    chk(selValid == 0, "R9", selValid, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) tick;
    rst_n = 1;
    // R10 reset state
    regAddr = 1; #1;
    chk(regRdData == 0, "R10", regRdData, 0);
    regAddr = 0; #1;
    chk(regRdData == 0, "R10", regRdData, 0);
    chk(cpuIrq == 0 && selValid == 0, "R10", {cpuIrq, selValid}, 0);

    // R6 mask write/read, status read, status write ignored
    lfsr = 32'hACE1_1234;
    for (int t = 0; t < 16; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wrMask(lfsr);
      regAddr = 1; #1;
      chk(regRdData == lfsr, "R6", regRdData, lfsr);
      irqRaw = ~lfsr; tick;
      regAddr = 0; #1;
      chk(regRdData == ~lfsr, "R1", regRdData, ~lfsr);
    end
    regAddr = 0; regWrEn = 1; regWrData = 32'h5A5A_0F0F; tick; regWrEn = 0;
    chk(regRdData == irqRaw, "R6", regRdData, irqRaw);
    regAddr = 1; #1;
    chk(regRdData == maskM, "R6", regRdData, maskM);

    // R7 single-bit sweep
    wrMask('0);
    for (int i = 0; i < W; i++) begin
      maskIdx = IW'(i); maskSetEn = 1; tick; maskSetEn = 0;
      maskM[i] = 1'b1;
      regAddr = 1; #1;
      chk(regRdData == maskM, "R7", regRdData, maskM);
    end
    for (int i = 0; i < W; i += 3) begin
      maskIdx = IW'(i); maskClrEn = 1; tick; maskClrEn = 0;
      maskM[i] = 1'b0;
      #1; chk(regRdData == maskM, "R7", regRdData, maskM);
    end
    maskIdx = 5'd4; maskSetEn = 1; maskClrEn = 1; tick; maskSetEn = 0; maskClrEn = 0;
    maskM[4] = 1'b0; #1;
    chk(regRdData == maskM, "R7", regRdData, maskM);
    maskIdx = 5'd0; maskClrEn = 1; regWrEn = 1; regWrData = 32'h0000_00FF; tick;
    maskClrEn = 0; regWrEn = 0; maskM = 32'h0000_00FF; #1;
    chk(regRdData == maskM, "R7", regRdData, maskM);

    // R1 / R2 combined line
    irqRaw = 32'h0000_0100; tick; tick;
    chk(cpuIrq == 0, "R2", cpuIrq, 0);
    irqRaw = 32'h0000_0080; tick;
    chk(cpuIrq == 0, "R2", cpuIrq, 0);
    tick;
    chk(cpuIrq == 1, "R2", cpuIrq, 1);
    wrMask('0);
    chk(cpuIrq == 1, "R2", cpuIrq, 1);
    tick;
    chk(cpuIrq == 0, "R1", cpuIrq, 0);

    // R4 / R5 full rotation with wrap and cascade remap
    irqRaw = '1; wrMask('1); tick;
    for (int t = 0; t < 2 * W + 5; t++) serveOnce("R4");

    // R3 idle request keeps the pointer
    wrMask('0);
    serveOnce("R3");
    serveOnce("R3");
    wrMask('1);
    serveOnce("R3");

    // R4 sparse patterns
    lfsr = 32'h1357_9BDF;
    for (int t = 0; t < 200; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irqRaw = lfsr & {lfsr[15:0], lfsr[31:16]};
      if (t % 7 == 0) wrMask(lfsr ^ 32'hF0F0_0F0F);
      tick;
      serveOnce("R5");
    end
    // R9 held request pulses each cycle
    irqRaw = 32'h8000_0001; wrMask('1); tick;
    serviceReq = 1; tick;
    chk(selValid == 1, "R9", selValid, 1);
    tick;
    chk(selValid == 1, "R9", selValid, 1);
    serviceReq = 0; tick;
    chk(selValid == 0, "R9", selValid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule